// File: doc/BRIEF.md
# Nibble-Pair Key Loader

This block reads a 48-bit authentication key out of a byte-wide nonvolatile key area and rebuilds it from its protected stored form. Every plain key byte is kept as two stored bytes. Each stored byte carries one nibble of the key in bits 3:0 and the bitwise inverse of that same nibble in bits 7:4. The high nibble's stored byte comes first, and then the low nibble's. Key byte 0 is stored first and ends up in the least significant byte of the assembled key.

A host drives a start address and pulses a load strobe. The loader refuses any start address whose 12-byte span would leave the key window 080h..1FFh. For an accepted address it streams twelve consecutive reads through a synchronous memory port with one cycle of read latency. It checks every stored byte, and it commits the rebuilt key only when all twelve bytes pass. When the load finishes, a one-cycle done pulse reports the result through a key-valid flag and a two-bit error code. A separate combinational encoder turns a plain byte into its two stored bytes for the write path.

Top module: `nk_key_loader`

## Requirements
- R1: The encoder maps plain byte p to first = {~p[7:4], p[7:4]} and second = {~p[3:0], p[3:0]}. For example, A0h gives 5Ah, F0h and A5h gives 5Ah, A5h.
- R2: A load whose start address is below 080h or above 1F4h is refused. No read is issued, done pulses on the edge that samples load, err_code becomes 2 (range), key_valid becomes 0, and busy never rises.
- R3: An accepted load issues exactly 12 reads, one per cycle, at addresses start, start+1, ..., start+11. These run straight across 16-byte block boundaries, so a start at 12Fh reads up to 13Ah.
- R4: A stored byte is well formed only if bits 7:4 equal the inverse of bits 3:0. If any of the 12 bytes is not well formed, the load ends with err_code 1 (format) and key_valid 0.
- R5: Stored byte 2i supplies key bits [8i+7:8i+4] and stored byte 2i+1 supplies key bits [8i+3:8i], so key byte 0 is the first pair read.
- R6: The key output changes only on a load that ends with err_code 0 (valid, key_valid 1). A failed or refused load keeps the previous key.
- R7: For an accepted load, busy is high from the edge that samples load until done. Done rises on the 13th clock edge after that sampling edge, lasts one cycle, and is never high together with busy.
- R8: A load strobe that arrives while busy is high is ignored. The running load keeps its addresses and its result.
- R9: The start addresses 080h and 1F4h are accepted. The start addresses 07Fh and 1F5h are refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load strobe, sampled when idle |
| start_addr | input | 9 | Byte address of the first stored byte |
| mem_rd_en | output | 1 | Read enable to the key memory |
| mem_addr | output | 9 | Read address to the key memory |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| key_valid | output | 1 | Last completed load succeeded |
| err_code | output | 2 | 0 none, 1 format, 2 range |
| key | output | 48 | Assembled key, byte 0 in bits 7:0 |
| enc_plain | input | 8 | Plain byte for the encoder |
| enc_first | output | 8 | Stored byte carrying the high nibble |
| enc_second | output | 8 | Stored byte carrying the low nibble |

## Verification
The bench loads keys that start on the last byte of a block, and a design that wrapped within the block or realigned the start would read the wrong bytes and return a different key. It probes both edges of the legal start window, where an off-by-one limit would read past 1FFh or refuse a legal key. It corrupts a single middle byte, which shows up a checker that only samples some bytes or a loader that commits the key anyway. It also fires a second strobe during a load, which a loader that restarts would answer with a second done or a broken address run.

// File: rtl/nk_pkg.sv
package nk_pkg;
  typedef enum logic [1:0] {
    NK_ERR_NONE   = 2'd0,
    NK_ERR_FORMAT = 2'd1,
    NK_ERR_RANGE  = 2'd2
  } nk_err_e;
endpackage

// File: rtl/nk_encode.sv
module nk_encode #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] plain,
  output logic [DW-1:0] first_o,
  output logic [DW-1:0] second_o
);
  localparam int NW = DW / 2;

  // each half travels with its own complement above it
  assign first_o  = {~plain[DW-1:NW], plain[DW-1:NW]};
  assign second_o = {~plain[NW-1:0],  plain[NW-1:0]};
endmodule

// File: rtl/nk_pair_check.sv
module nk_pair_check #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   stored,
  output logic [DW/2-1:0] nib,
  output logic            ok
);
  localparam int NW = DW / 2;

  assign nib = stored[NW-1:0];
  assign ok  = (stored[DW-1:NW] == ~stored[NW-1:0]);
endmodule

// File: rtl/nk_range_check.sv
module nk_range_check #(
  parameter int AW      = 9,
  parameter int AREA_LO = 128,
  parameter int AREA_HI = 511,
  parameter int SPAN    = 12
) (
  input  logic [AW-1:0] start,
  output logic          in_range
);
  localparam logic [AW-1:0] LO_A   = AW'(AREA_LO);
  localparam logic [AW-1:0] LAST_A = AW'(AREA_HI - SPAN + 1);

  assign in_range = (start >= LO_A) && (start <= LAST_A);
endmodule

// File: rtl/nk_key_loader.sv
module nk_key_loader #(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int KEY_BYTES = 6,
  parameter int AREA_LO   = 128,
  parameter int AREA_HI   = 511
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [AW-1:0]         start_addr,
  output logic                  mem_rd_en,
  output logic [AW-1:0]         mem_addr,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  key_valid,
  output logic [1:0]            err_code,
  output logic [KEY_BYTES*DW-1:0] key,
  input  logic [DW-1:0]         enc_plain,
  output logic [DW-1:0]         enc_first,
  output logic [DW-1:0]         enc_second
);
  import nk_pkg::*;

  localparam int NW     = DW / 2;
  localparam int STORED = 2 * KEY_BYTES;
  localparam int KW     = KEY_BYTES * DW;
  localparam int CW     = $clog2(STORED + 1);
  localparam logic [AW-1:0] LO_A = AW'(AREA_LO);
  localparam logic [AW-1:0] HI_A = AW'(AREA_HI);

  logic          in_range;
  logic          byte_ok;
  logic [NW-1:0] nib;
  logic [CW-1:0] issue_cnt;
  logic [CW-1:0] rcv_cnt;
  logic [CW-1:0] nib_sel;
  logic          data_vld;
  logic          fmt_bad;
  logic [KW-1:0] stage;
  logic [KW-1:0] stage_nxt;
  logic          last_rcv;

  nk_encode #(.DW(DW)) enc_u (
    .plain(enc_plain), .first_o(enc_first), .second_o(enc_second)
  );

  nk_pair_check #(.DW(DW)) chk_u (
    .stored(mem_rdata), .nib(nib), .ok(byte_ok)
  );

  nk_range_check #(.AW(AW), .AREA_LO(AREA_LO), .AREA_HI(AREA_HI), .SPAN(STORED)) rng_u (
    .start(start_addr), .in_range(in_range)
  );

  // even stored index -> upper nibble slot, odd -> lower nibble slot
  assign nib_sel  = {rcv_cnt[CW-1:1], ~rcv_cnt[0]};
  assign last_rcv = data_vld && (rcv_cnt == CW'(STORED - 1));

  always_comb begin
    stage_nxt = stage;
    for (int i = 0; i < STORED; i++) begin
      if (CW'(i) == nib_sel) stage_nxt[i*NW +: NW] = nib;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      key_valid <= 1'b0;
      err_code  <= NK_ERR_NONE;
      key       <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      issue_cnt <= '0;
      rcv_cnt   <= '0;
      data_vld  <= 1'b0;
      fmt_bad   <= 1'b0;
      stage     <= '0;
    end else begin
      done     <= 1'b0;
      data_vld <= mem_rd_en;
      if (!busy) begin
        if (load) begin
          if (in_range) begin
            busy      <= 1'b1;
            mem_rd_en <= 1'b1;
            mem_addr  <= start_addr;
            issue_cnt <= CW'(1);
            rcv_cnt   <= '0;
            fmt_bad   <= 1'b0;
          end else begin
            done      <= 1'b1;
            err_code  <= NK_ERR_RANGE;
            key_valid <= 1'b0;
          end
        end
      end else begin
        if (mem_rd_en) begin
          if (issue_cnt == CW'(STORED)) begin
            mem_rd_en <= 1'b0;
          end else begin
            mem_addr  <= mem_addr + 1'b1;
            issue_cnt <= issue_cnt + 1'b1;
          end
        end
        if (data_vld) begin
          stage   <= stage_nxt;
          rcv_cnt <= rcv_cnt + 1'b1;
          if (!byte_ok) fmt_bad <= 1'b1;
          if (last_rcv) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (fmt_bad || !byte_ok) begin
              err_code  <= NK_ERR_FORMAT;
              key_valid <= 1'b0;
            end else begin
              err_code  <= NK_ERR_NONE;
              key_valid <= 1'b1;
              key       <= stage_nxt;
            end
          end
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R7
  AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_rd_en); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R3
  AST_ADDR_IN_AREA: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_addr >= LO_A && mem_addr <= HI_A)); // R9
  AST_KEY_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (done && err_code != NK_ERR_NONE) |-> $stable(key)); // R6
  AST_VALID_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (key_valid == (err_code == NK_ERR_NONE))); // R4
endmodule

// File: tb/nk_key_loader_tb_top.sv
module nk_key_loader_tb_top;
  typedef struct {
    logic [1:0]  err;
    logic        valid;
    logic [47:0] key;
    int          lat;
    int          nreads;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [8:0]  start_addr = '0;
  logic        mem_rd_en;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, done, key_valid;
  logic [1:0]  err_code;
  logic [47:0] key;
  logic [7:0]  enc_plain = '0;
  logic [7:0]  enc_first, enc_second;

  logic [7:0]  mem [0:511];
  exp_t        q[$];
  int          n_checks = 0;
  int          n_err = 0;
  int          cyc = 0;
  int          t0 = 0;
  int          exp_next = 0;
  int          rd_count = 0;
  int          results_seen = 0;
  bit          finished = 1'b0;
  logic [47:0] model_key = '0;

  always #5 clk = ~clk;

  nk_key_loader dut_i (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .key_valid(key_valid), .err_code(err_code),
    .key(key), .enc_plain(enc_plain), .enc_first(enc_first), .enc_second(enc_second)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: address trace and scoreboard
  always @(negedge clk) begin
    if (!rst && mem_rd_en) begin
      check_eq("R3", "read address", 64'(mem_addr), 64'(exp_next));
      exp_next++;
      rd_count++;
    end
    if (!rst && done) begin
      if (q.size() == 0) begin
        check_eq("R8", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check_eq("R4", "err_code", 64'(err_code), 64'(e.err));
        check_eq("R4", "key_valid", 64'(key_valid), 64'(e.valid));
        check_eq("R6", "key", 64'(key), 64'(e.key));
        check_eq("R7", "done latency", 64'(cyc - t0), 64'(e.lat));
        check_eq("R3", "read count", 64'(rd_count), 64'(e.nreads));
        check_eq("R7", "busy at done", 64'(busy), 64'd0);
      end
      results_seen++;
    end
  end

  task automatic put_key(input int a, input logic [47:0] k);
    for (int i = 0; i < 6; i++) begin
      logic [3:0] hi, lo;
      hi = k[8*i+4 +: 4];
      lo = k[8*i +: 4];
      mem[a + 2*i]     = {~hi, hi};
      mem[a + 2*i + 1] = {~lo, lo};
    end
  endtask

  task automatic pulse_load(input logic [8:0] a);
    @(negedge clk);
    start_addr = a;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_results(input int target);
    while (results_seen < target) @(negedge clk);
  endtask

  // kind: 0 success, 1 format error, 2 range error
  task automatic run_load(input logic [8:0] a, input int kind, input logic [47:0] k,
                          input string req);
    exp_t e;
    int   target;
    target = results_seen + 1;
    e.err = 2'(kind);
    e.valid = (kind == 0);
    if (kind == 0) model_key = k;
    e.key = model_key;
    e.lat = (kind == 2) ? 1 : 14;
    e.nreads = (kind == 2) ? 0 : 12;
    q.push_back(e);
    exp_next = int'(a);
    rd_count = 0;
    @(negedge clk);
    start_addr = a;
    load = 1'b1;
    t0 = cyc;
    @(negedge clk);
    load = 1'b0;
    if (kind != 2) check_eq(req, "busy after accept", 64'(busy), 64'd1);
    else check_eq(req, "busy after refuse", 64'(busy), 64'd0);
    wait_results(target);
    @(negedge clk);
    check_eq(req, "done clears", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R7", "reset busy", 64'(busy), 64'd0);
    check_eq("R7", "reset done", 64'(done), 64'd0);
    check_eq("R6", "reset key", 64'(key), 64'd0);
    check_eq("R4", "reset key_valid", 64'(key_valid), 64'd0);
    check_eq("R2", "reset rd_en", 64'(mem_rd_en), 64'd0);

    // R1 encoder
    enc_plain = 8'hA0; #1;
    check_eq("R1", "enc A0 first", 64'(enc_first), 64'h5A);
    check_eq("R1", "enc A0 second", 64'(enc_second), 64'hF0);
    enc_plain = 8'hA5; #1;
    check_eq("R1", "enc A5 first", 64'(enc_first), 64'h5A);
    check_eq("R1", "enc A5 second", 64'(enc_second), 64'hA5);
    enc_plain = 8'h3C; #1;
    check_eq("R1", "enc 3C first", 64'(enc_first), 64'hC3);
    check_eq("R1", "enc 3C second", 64'(enc_second), 64'h3C);

    // R3 R5: start on last byte of a block
    put_key(9'h12F, 48'hA5A4A3A2A1A0);
    check_eq("R5", "stored byte 0", 64'(mem[9'h12F]), 64'h5A);
    check_eq("R5", "stored byte 11", 64'(mem[9'h13A]), 64'hA5);
    run_load(9'h12F, 0, 48'hA5A4A3A2A1A0, "R5");

    // R9 window edges
    put_key(9'h080, 48'h0123456789AB);
    run_load(9'h080, 0, 48'h0123456789AB, "R9");
    put_key(9'h1F4, 48'hFEDCBA987654);
    run_load(9'h1F4, 0, 48'hFEDCBA987654, "R9");
    run_load(9'h1F5, 2, 48'h0, "R2");
    run_load(9'h07F, 2, 48'h0, "R2");
    check_eq("R6", "key kept after refusal", 64'(key), 64'hFEDCBA987654);

    // R4 R6: one corrupted byte mid-key
    put_key(9'h150, 48'h111122223333);
    mem[9'h155] = mem[9'h155] ^ 8'h10;
    run_load(9'h150, 1, 48'h0, "R4");
    check_eq("R6", "key kept after format error", 64'(key), 64'hFEDCBA987654);

    // R8: second strobe while busy is ignored
    put_key(9'h170, 48'hC0FFEE123456);
    begin
      exp_t e;
      int   target;
      target = results_seen + 1;
      e.err = 2'd0; e.valid = 1'b1; e.key = 48'hC0FFEE123456;
      e.lat = 14; e.nreads = 12;
      model_key = e.key;
      q.push_back(e);
      exp_next = 9'h170;
      rd_count = 0;
      @(negedge clk);
      start_addr = 9'h170;
      load = 1'b1;
      t0 = cyc;
      @(negedge clk);
      load = 1'b0;
      repeat (3) @(negedge clk);
      pulse_load(9'h080);
      wait_results(target);
      repeat (16) @(negedge clk);
      check_eq("R8", "results after ignored strobe", 64'(results_seen), 64'(target));
      check_eq("R8", "key from first load", 64'(key), 64'hC0FFEE123456);
    end

    // recovery after the format error
    mem[9'h155] = mem[9'h155] ^ 8'h10;
    run_load(9'h150, 0, 48'h111122223333, "R5");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule